// File: doc/BRIEF.md
# Load Data Alignment Formatter

This block sits at the end of the load path of a load/store unit. It takes the aligned 64-bit doubleword read from memory, plus the low three address bits and the access attributes of the load. It produces the final register value, so the writeback stage only has to pass that value to the register file. In a single registered stage it brings the addressed byte down to the least significant lane, optionally reverses the byte order of the item, and fills the bits above the item with zeros or with copies of its sign.

The load attributes are the access size, a byte-reverse flag and a sign-extend flag. The result and its valid appear one clock after the request. A load whose bytes would run past the end of the doubleword produces no result. Instead it raises an error flag for one cycle and leaves the held result unchanged.

Top module: `ldfmt_top`

## Requirements
- R1: The item is taken starting at byte lane `addrLow` of `memData`, so that byte `addrLow` of the doubleword appears in bits [7:0] of `outData`, byte `addrLow+1` in bits [15:8], and so on.
- R2: `accSize` selects the item width: 2'b00 is 1 byte, 2'b01 is 2 bytes, 2'b10 is 4 bytes and 2'b11 is 8 bytes. Only that many bytes, counted from the addressed lane, form the item.
- R3: With `byteRev` high, the order of the bytes is reversed within the item width only. For example, with a 4-byte item, output byte 0 is the fourth addressed byte and output byte 3 is the first.
- R4: With `signExt` high and a width below 8 bytes, every bit above the item equals bit 7 of the item's top byte. That top byte is taken after any reversal.
- R5: With `signExt` low and a width below 8 bytes, every bit above the item is zero.
- R6: An 8-byte load gives the same result whatever the value of `signExt`.
- R7: An accepted load drives `outValid` high, with its result on `outData`, exactly one clock after `inValid`. `outValid` is a single-cycle pulse for each load.
- R8: In a cycle after `inValid` was low, `outValid` is low and `outData` keeps its previous value.
- R9: A load with `addrLow` + item bytes > 8 raises `outErr` in the following cycle, keeps `outValid` low and leaves `outData` unchanged. `outErr` and `outValid` are never high together.
- R10: A synchronous active-high `rst` clears `outValid`, `outErr` and `outData` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A load's memory data and attributes are present |
| memData | input | 64 | Aligned doubleword read from memory |
| addrLow | input | 3 | Byte offset of the load inside the doubleword |
| accSize | input | 2 | Item width code (1, 2, 4 or 8 bytes) |
| byteRev | input | 1 | Reverse byte order within the item |
| signExt | input | 1 | Fill the upper bits with the item's sign instead of zeros |
| outValid | output | 1 | Formatted result is valid this cycle |
| outErr | output | 1 | The previous load ran past the doubleword end |
| outData | output | 64 | Formatted 64-bit register value |

## Verification
The formatter is swept over every combination of offset, width, reverse flag and sign flag. This is repeated for three data words:
- Ascending distinct bytes show any wrong lane selection or wrong reversal order.
- A word whose every byte has its top bit set separates sign fill from zero fill.
- A pseudo-random word exercises mixed sign bits.

Each load is followed by an idle cycle, which shows that the result is held and that the valid signal is a single pulse. The combinations that overrun the doubleword check that the error is raised and that the held result is left alone.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int LANE_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic fault;
  } ldStrobe_t;
endpackage

// File: rtl/ldfmt_ctrl.sv
module ldfmt_ctrl #(
  parameter int BYTES = 8
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    inValid,
  input  logic [$clog2(BYTES)-1:0]                addrLow,
  input  logic [$clog2($clog2(BYTES)+1)-1:0]      accSize,
  output ldfmt_pkg::ldStrobe_t                    strobe,
  output logic                                    outValid,
  output logic                                    outErr
);
  localparam int OFS_W  = $clog2(BYTES);
  localparam int SPAN_W = OFS_W + 2;

  logic [SPAN_W-1:0] itemBytes;
  logic [SPAN_W-1:0] span;
  logic              overrun;

  always_comb begin
    itemBytes       = SPAN_W'(1) << accSize;
    span            = SPAN_W'(addrLow) + itemBytes;
    overrun         = span > SPAN_W'(BYTES);
    strobe.capture  = inValid & ~overrun;
    strobe.fault    = inValid & overrun;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outErr   <= 1'b0;
    end else begin
      outValid <= strobe.capture;
      outErr   <= strobe.fault;
    end
  end
endmodule

// File: rtl/ldfmt_datapath.sv
module ldfmt_datapath #(
  parameter int BYTES = 8
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  ldfmt_pkg::ldStrobe_t                    strobe,
  input  logic [BYTES*ldfmt_pkg::LANE_W-1:0]      memData,
  input  logic [$clog2(BYTES)-1:0]                addrLow,
  input  logic [$clog2($clog2(BYTES)+1)-1:0]      accSize,
  input  logic                                    byteRev,
  input  logic                                    signExt,
  output logic [BYTES*ldfmt_pkg::LANE_W-1:0]      outData
);
  localparam int LW        = ldfmt_pkg::LANE_W;
  localparam int OFS_W     = $clog2(BYTES);
  localparam int NUM_SIZES = OFS_W + 1;

  logic [BYTES-1:0][LW-1:0] memBytes;
  logic [BYTES-1:0][LW-1:0] rotBytes;
  logic [BYTES-1:0][LW-1:0] revBytes [NUM_SIZES];
  logic [BYTES-1:0][LW-1:0] itemBytes;
  logic [BYTES-1:0][LW-1:0] result;

  assign memBytes = memData;

  // rotate: lane b takes memory byte (b + offset) mod BYTES
  for (genvar b = 0; b < BYTES; b++) begin : g_rot
    assign rotBytes[b] = memBytes[OFS_W'(b) + addrLow];
  end

  // one reversed variant per item width
  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int NB = 1 << s;
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
      if (b < NB) begin : g_swap
        assign revBytes[s][b] = rotBytes[NB-1-b];
      end else begin : g_keep
        assign revBytes[s][b] = rotBytes[b];
      end
    end
  end

  always_comb begin
    logic signBit;
    int   nb;
    itemBytes = byteRev ? revBytes[accSize] : rotBytes;
    nb        = 1 << accSize;
    signBit   = 1'b0;
    for (int b = 0; b < BYTES; b++) begin
      if (b == nb - 1) signBit = signExt & itemBytes[b][LW-1];
    end
    for (int b = 0; b < BYTES; b++) begin
      result[b] = (b < nb) ? itemBytes[b] : {LW{signBit}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 outData <= '0;
    else if (strobe.capture) outData <= result;
  end
endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top #(
  parameter int BYTES = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                inValid,
  input  logic [BYTES*8-1:0]                  memData,
  input  logic [$clog2(BYTES)-1:0]            addrLow,
  input  logic [$clog2($clog2(BYTES)+1)-1:0]  accSize,
  input  logic                                byteRev,
  input  logic                                signExt,
  output logic                                outValid,
  output logic                                outErr,
  output logic [BYTES*8-1:0]                  outData
);
  ldfmt_pkg::ldStrobe_t strobe;

  ldfmt_ctrl #(.BYTES(BYTES)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .addrLow  (addrLow),
    .accSize  (accSize),
    .strobe   (strobe),
    .outValid (outValid),
    .outErr   (outErr)
  );

  ldfmt_datapath #(.BYTES(BYTES)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .memData (memData),
    .addrLow (addrLow),
    .accSize (accSize),
    .byteRev (byteRev),
    .signExt (signExt),
    .outData (outData)
  );
endmodule

// File: rtl/ldfmt_chk.sv
module ldfmt_chk #(
  parameter int BYTES = 8
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                inValid,
  input logic [$clog2(BYTES)-1:0]            addrLow,
  input logic [$clog2($clog2(BYTES)+1)-1:0]  accSize,
  input logic                                signExt,
  input logic                                outValid,
  input logic                                outErr,
  input logic [BYTES*8-1:0]                  outData
);
  localparam int DW = BYTES * 8;
  localparam int SW = $clog2(BYTES) + 2;

  logic fits;
  assign fits = (SW'(addrLow) + (SW'(1) << accSize)) <= SW'(BYTES);

  // R7: accepted load gives valid next cycle
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    (inValid && fits) |=> outValid);

  // R9: overrun gives error, no valid, held data
  a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
    (inValid && !fits) |=> (outErr && !outValid && $stable(outData)));

  // R9: never both flags
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outErr));

  // R8: idle input holds result and drops valid
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(outData)));

  // R5: byte load without sign flag clears upper bits
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (inValid && accSize == '0 && !signExt) |=> (outData[DW-1:8] == '0));

  // R4: byte load with sign flag replicates bit 7
  a_r4_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (inValid && accSize == '0 && signExt) |=> (outData[DW-1:8] == {(DW-8){outData[7]}}));

  // R10: reset clears flags
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!outValid && !outErr && outData == '0));
endmodule

bind ldfmt_top ldfmt_chk #(.BYTES(BYTES)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .addrLow  (addrLow),
  .accSize  (accSize),
  .signExt  (signExt),
  .outValid (outValid),
  .outErr   (outErr),
  .outData  (outData)
);

// File: tb/ldfmt_top_tb_top.sv
module ldfmt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [63:0] memData;
  logic [2:0]  addrLow;
  logic [1:0]  accSize;
  logic        byteRev;
  logic        signExt;
  logic        outValid;
  logic        outErr;
  logic [63:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  logic [63:0] lastData;

  always #4 clk = ~clk;  // 125 MHz

  ldfmt_top dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .memData(memData),
    .addrLow(addrLow), .accSize(accSize), .byteRev(byteRev),
    .signExt(signExt), .outValid(outValid), .outErr(outErr),
    .outData(outData)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] mem, input int off,
                                        input int sz, input bit rev, input bit sx);
    logic [63:0] e;
    int nb;
    int src;
    bit sgn;
    e  = '0;
    nb = 1 << sz;
    for (int i = 0; i < nb; i++) begin
      src = rev ? (off + nb - 1 - i) : (off + i);
      e[i*8 +: 8] = mem[src*8 +: 8];
    end
    sgn = e[nb*8-1];
    for (int j = nb*8; j < 64; j++) e[j] = sx & sgn;
    return e;
  endfunction

  task automatic doLoad(input logic [63:0] mem, input int off, input int sz,
                        input bit rev, input bit sx);
    logic [63:0] exp;
    string tag;
    bit overrun;
    overrun = (off + (1 << sz)) > 8;
    @(negedge clk);
    inValid = 1'b1; memData = mem; addrLow = 3'(off);
    accSize = 2'(sz); byteRev = rev; signExt = sx;
    @(negedge clk);
    inValid = 1'b0;
    if (overrun) begin
      check(outErr == 1'b1 && outValid == 1'b0, "R9 flags",
            {62'b0, outErr, outValid}, 64'h2);
      check(outData == lastData, "R9 data held", outData, lastData);
    end else begin
      exp = model(mem, off, sz, rev, sx);
      if (rev)             tag = "R3";
      else if (sz == 3)    tag = sx ? "R6" : "R1";
      else if (sx)         tag = "R4";
      else                 tag = "R2 R5";
      check(outData == exp, tag, outData, exp);
      check(outValid == 1'b1 && outErr == 1'b0, "R7 valid",
            {62'b0, outErr, outValid}, 64'h1);
      lastData = exp;
    end
    @(negedge clk);
    check(outValid == 1'b0 && outErr == 1'b0 && outData == lastData, "R8 hold",
          outData, lastData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [63:0] pats [3];
    pats[0] = 64'h8877665544332211;
    pats[1] = 64'hF8E8D8C8B8A89888;
    pats[2] = {$urandom(7), $urandom()};
    rst = 1'b1; inValid = 1'b0; memData = '0; addrLow = '0;
    accSize = '0; byteRev = 1'b0; signExt = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outErr == 1'b0 && outData == '0, "R10 reset",
          outData, 64'h0);
    rst = 1'b0;
    lastData = '0;
    for (int p = 0; p < 3; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++)
          for (int rv = 0; rv < 2; rv++)
            for (int sx = 0; sx < 2; sx++)
              doLoad(pats[p], off, sz, rv[0], sx[0]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(outValid == 1'b0 && outErr == 1'b0 && outData == '0, "R10 reset again",
          outData, 64'h0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule